// File: doc/BRIEF.md
# Doorbell-Gated Command Sequencer

This block decides when an execution unit may take the next command from its command queue. It keeps a signed credit count, called the doorbell. Software raises or lowers the count by writing a signed increment. The hardware spends one credit each time it takes a bus-acquire command from the head of the queue. If a bus-acquire command reaches the head while the count is zero or negative, the gate stops in a waiting state. It leaves that state only when software writes a non-zero increment.

Software normally loads one or more acquire…release sequences into the queue and then writes the number of sequences in a single doorbell write. A separate execution-disable input lets the commands already in the queue finish and then holds back anything loaded later. An idle flag reports when nothing is queued and the execution unit has gone quiet.

Top module: `doorbell_cmd_gate`

## Requirements
- R1: A write with `db_wr_en` high adds `db_wr_data`, read as a two's-complement value, to `db_count`. The new value is visible one cycle after the write.
- R2: Each bus-acquire command taken (`cmd_pop` high while `cmd_is_acq` is high) lowers `db_count` by 1 in the next cycle. A write of N credits lets exactly N acquire commands pass.
- R3: When the head command is a bus-acquire and `db_count` is zero or negative (bit 7 set), the command is not taken and `stalled` goes high in the next cycle.
- R4: While `stalled` is high, no command is taken. `stalled` stays high until a cycle in which software writes a non-zero value. After that cycle the head is tested again against the new count.
- R5: A write and an acquire take in the same cycle leave `db_count` equal to old count plus increment minus 1.
- R6: Count arithmetic wraps modulo 256. 127 plus 1 gives 0x80, which counts as negative and blocks an acquire.
- R7: When `exec_disable` rises, the commands present at that moment (`fifo_level` in the rising cycle) may still be taken. After that, no command is taken while `exec_disable` stays high, even if more are loaded.
- R8: When `exec_disable` is low and the queue is not empty, commands are taken again.
- R9: `idle` is 1 only when `fifo_level` is 0 and `exec_busy` is 0.
- R10: After reset, `db_count` is 0, `stalled` is 0 and the gate is not draining.
- R11: A non-acquire command is taken regardless of the count and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_wr_en | input | 1 | Software doorbell write strobe |
| db_wr_data | input | 8 | Signed increment written to the doorbell |
| db_count | output | 8 | Current two's-complement doorbell count |
| cmd_valid | input | 1 | Queue holds at least one command |
| cmd_is_acq | input | 1 | Head command is a bus-acquire |
| fifo_level | input | 5 | Number of commands in the queue |
| exec_busy | input | 1 | Execution unit still working on a sequence |
| exec_disable | input | 1 | Drain the current queue contents, then hold |
| cmd_pop | output | 1 | Head command is taken this cycle |
| stalled | output | 1 | Gate is waiting for a non-zero doorbell write |
| idle | output | 1 | Queue empty and execution unit quiet |

## Verification
Two things can hit the count in the same cycle: a software doorbell write and a hardware credit spend on a bus-acquire. The bench provokes this on purpose. It writes an increment in the same cycle an acquire is at the head, both with explicit values and across a sweep of all 256 write values. It then checks the count against an arithmetic model that applies both changes modulo 256. A second collision comes from a write arriving in the very cycle a fetch would stall. The model expects the write to clear the stall, so the head is tested again in the next cycle.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic {
    GATE_RUN  = 1'b0,
    GATE_WAIT = 1'b1
  } gate_st_e;
endpackage

// File: rtl/db_credit.sv
module db_credit #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          take,
  output logic [CW-1:0] count,
  output logic          credit_low
);
  function automatic logic [CW-1:0] credit_next(input logic [CW-1:0] cur,
                                                 input logic [CW-1:0] inc,
                                                 input logic          spend);
    logic [CW-1:0] dec;
    dec = spend ? {{(CW-1){1'b0}}, 1'b1} : '0;
    return cur + inc - dec;
  endfunction

  function automatic logic not_positive(input logic [CW-1:0] v);
    return v[CW-1] || (v == '0);
  endfunction

  logic [CW-1:0] inc_eff;
  assign inc_eff    = wr_en ? wr_val : '0;
  assign credit_low = not_positive(count);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= credit_next(count, inc_eff, take);
  end

  // R2
  spend_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> (count + 1'b1) == $past(count));
  // R1
  write_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !take) |=> count == $past(count) + $past(wr_val));
endmodule

// File: rtl/fetch_gate.sv
module fetch_gate
  import doorbell_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic          head_acq,
  input  logic          credit_low,
  input  logic          release_wr,
  input  logic          xdis,
  input  logic [LW-1:0] level,
  output logic          pop,
  output logic          take,
  output logic          stalled
);
  gate_st_e      st_q;
  logic          dis_q;
  logic [LW-1:0] drain_q;
  logic          dis_rise, run_ok, blocked;

  assign dis_rise = xdis && !dis_q;
  assign run_ok   = !xdis || dis_rise || (drain_q != '0);
  assign blocked  = run_ok && head_valid && head_acq && credit_low && (st_q == GATE_RUN);
  assign pop      = run_ok && head_valid && (st_q == GATE_RUN) && !(head_acq && credit_low);
  assign take     = pop && head_acq;
  assign stalled  = (st_q == GATE_WAIT);

  logic [LW-1:0] pop_w;
  assign pop_w = {{(LW-1){1'b0}}, pop};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= GATE_RUN;
      dis_q   <= 1'b0;
      drain_q <= '0;
    end else begin
      dis_q <= xdis;
      if (release_wr)   st_q <= GATE_RUN;
      else if (blocked) st_q <= GATE_WAIT;
      if (!xdis)                         drain_q <= '0;
      else if (dis_rise)                 drain_q <= (level > pop_w) ? level - pop_w : '0;
      else if (pop && drain_q != '0)     drain_q <= drain_q - 1'b1;
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !release_wr) |=> stalled);
  // R4
  stall_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !pop);
  // R7
  halt_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xdis && dis_q && drain_q == '0) |-> !pop);
endmodule

// File: rtl/doorbell_cmd_gate.sv
module doorbell_cmd_gate #(
  parameter int CW    = 8,
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_wr_en,
  input  logic [CW-1:0]    db_wr_data,
  output logic [CW-1:0]    db_count,
  input  logic             cmd_valid,
  input  logic             cmd_is_acq,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             exec_busy,
  input  logic             exec_disable,
  output logic             cmd_pop,
  output logic             stalled,
  output logic             idle
);
  logic credit_low, take, release_wr;

  assign release_wr = db_wr_en && (db_wr_data != '0);
  assign idle       = (fifo_level == '0) && !exec_busy;

  db_credit #(.CW(CW)) u_credit (
    .clk(clk), .rst_n(rst_n), .wr_en(db_wr_en), .wr_val(db_wr_data),
    .take(take), .count(db_count), .credit_low(credit_low)
  );

  fetch_gate #(.LW(LVL_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .head_valid(cmd_valid), .head_acq(cmd_is_acq),
    .credit_low(credit_low), .release_wr(release_wr), .xdis(exec_disable),
    .level(fifo_level), .pop(cmd_pop), .take(take), .stalled(stalled)
  );

  // R3
  acq_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pop && cmd_is_acq) |-> !(db_count[CW-1] || db_count == '0));
endmodule

// File: tb/doorbell_cmd_gate_tb.sv
module doorbell_cmd_gate_tb;
  logic clk = 0, rst_n = 0;
  logic db_wr_en = 0, cmd_valid = 0, cmd_is_acq = 0, exec_busy = 0, exec_disable = 0;
  logic [7:0] db_wr_data = 0;
  logic [4:0] fifo_level = 0;
  logic [7:0] db_count;
  logic cmd_pop, stalled, idle;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] cnt_m;
  logic stall_m, disq_m, pop_seen;
  logic [4:0] drain_m;
  int pops_total;

  always #4 clk = ~clk;

  doorbell_cmd_gate u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; db_wr_en = 0; cmd_valid = 0; cmd_is_acq = 0; exec_disable = 0;
    fifo_level = 0; exec_busy = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
    cnt_m = 0; stall_m = 0; disq_m = 0; drain_m = 0;
  endtask

  task automatic step(input logic wr, input logic [7:0] d, input logic v, input logic a,
                      input logic dis, input logic [4:0] lvl, input logic busy);
    logic rise, run, low, blk, pexp;
    @(negedge clk);
    db_wr_en = wr; db_wr_data = d; cmd_valid = v; cmd_is_acq = a;
    exec_disable = dis; fifo_level = lvl; exec_busy = busy;
    #1;
    rise = dis && !disq_m;
    run  = !dis || rise || (drain_m != 0);
    low  = cnt_m[7] || (cnt_m == 0);
    blk  = run && v && a && low && !stall_m;
    pexp = run && v && !stall_m && !(a && low);
    chk(a ? "R3 pop" : (dis ? "R7 pop" : "R11 pop"), {7'd0, cmd_pop}, {7'd0, pexp});
    chk("R9 idle", {7'd0, idle}, {7'd0, (lvl == 0) && !busy});
    pop_seen = cmd_pop;
    if (cmd_pop) pops_total++;
    cnt_m   = cnt_m + (wr ? d : 8'd0) - ((pexp && a) ? 8'd1 : 8'd0);
    stall_m = (stall_m || blk) && !(wr && d != 0);
    if (!dis) drain_m = 0;
    else if (rise) drain_m = (lvl > {4'd0, pexp}) ? lvl - {4'd0, pexp} : 5'd0;
    else if (pexp && drain_m != 0) drain_m = drain_m - 1;
    disq_m = dis;
    @(posedge clk); #1;
    chk("R1 count", db_count, cnt_m);
    chk("R4 stalled", {7'd0, stalled}, {7'd0, stall_m});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    pops_total = 0;
    do_reset();
    // R10 reset state
    chk("R10 count", db_count, 8'd0);
    chk("R10 stalled", {7'd0, stalled}, 8'd0);
    chk("R9 idle at reset", {7'd0, idle}, 8'd1);

    // R3 acquire with zero credit stalls
    step(0, 0, 1, 1, 0, 4, 1);
    chk("R3 stall", {7'd0, stalled}, 8'd1);
    // R4 zero write keeps stall
    step(1, 0, 1, 1, 0, 4, 1);
    chk("R4 zero write", {7'd0, stalled}, 8'd1);
    step(1, 8'd2, 1, 1, 0, 4, 1);
    chk("R4 released", {7'd0, stalled}, 8'd0);
    step(0, 0, 1, 1, 0, 4, 1);
    chk("R2 spend", db_count, 8'd1);
    // R5 simultaneous write and spend
    step(1, 8'd3, 1, 1, 0, 4, 1);
    chk("R5 collide", db_count, 8'd3);
    // R11 non-acquire passes without spending
    step(0, 0, 1, 0, 0, 4, 1);
    chk("R11 pop", {7'd0, pop_seen}, 8'd1);
    chk("R11 count", db_count, 8'd3);
    // R1 negative increment
    step(1, 8'hFE, 0, 0, 0, 0, 0);
    chk("R1 neg add", db_count, 8'd1);

    // R2 multi-sequence credit: 3 credits let 3 acquires pass
    do_reset();
    step(1, 8'd3, 0, 0, 0, 0, 0);
    pops_total = 0;
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0, 8, 1);
    chk("R2 three passed", pops_total[7:0], 8'd3);
    chk("R2 then stall", {7'd0, stalled}, 8'd1);

    // R6 wrap to negative
    do_reset();
    step(1, 8'd127, 0, 0, 0, 0, 0);
    step(1, 8'd1, 0, 0, 0, 0, 0);
    chk("R6 wrap", db_count, 8'h80);
    step(0, 0, 1, 1, 0, 2, 0);
    chk("R6 negative blocks", {7'd0, pop_seen}, 8'd0);

    // R7 drain then hold, R8 resume
    do_reset();
    pops_total = 0;
    step(0, 0, 1, 0, 1, 3, 1);
    step(0, 0, 1, 0, 1, 2, 1);
    step(0, 0, 1, 0, 1, 1, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 1, 6, 1);
    chk("R7 drained only snapshot", pops_total[7:0], 8'd3);
    step(0, 0, 1, 0, 0, 6, 1);
    chk("R8 resume", {7'd0, pop_seen}, 8'd1);

    // R9 idle combinations
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R9 busy", {7'd0, idle}, 8'd0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9 quiet", {7'd0, idle}, 8'd1);

    // R1/R5 sweep over every write value with acquire fetches
    do_reset();
    for (int v = 0; v < 256; v++) step(1, v[7:0], 1, v[0], 0, 8, 1);
    for (int v = 0; v < 256; v++) step(v[1], v[7:0] ^ 8'h5A, 1, 1, 0, 8, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule